// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block is the storage side of a core-local vectored interrupt controller. A simple byte-addressed bus reaches it through a 32 KiB window that starts at a base address set by a parameter. Behind that window sit three things: one global configuration byte, an optional group of 32-bit trigger words, and one 32-bit control word for each interrupt source. Each control word packs four one-byte fields: a pending flag, an enable flag, attribute bits and a priority level. The block does no arbitration and sends nothing to the core. It only holds, masks and returns what software writes.

An access carries a byte address, a length of one to four bytes and, for a write, data. The first byte of the access is in lane 0 of the data bus. An access may start at any byte of a word. Bytes that would run past the end of that word are dropped. Every write to a control word is filtered through a fixed per-field mask. The level field keeps only its upper bits writable, and how many is set by a parameter. A read returns its data in the cycle after the request.

Top module: `irqbank_top`

## Requirements
- R1: After reset the configuration byte reads 0x30, and every control word and trigger word reads zero.
- R2: A write to the configuration byte changes only bits 4:1. Bits 7:5 and bit 0 keep their previous value.
- R3: A read at window offset 0 returns the configuration byte in lane 0 and zero in lanes 1 to 3. Offsets 1 to 3 of that word are unmapped.
- R4: After any write, a control word holds the written value ANDed with {level mask, 0xC7, 0x01, 0x01}. Byte 0 is the pending flag, byte 1 the enable flag, byte 2 the attributes and byte 3 the level.
- R5: In the level byte only the top LEVEL_BITS bits are writable, and the rest read as zero. With the default of 4 the mask is 0xF0, so a full-ones write reads back 0xF0C70101.
- R6: An access at byte offset o with len code n (n+1 bytes) touches word bytes o to min(o+n,3). Write lane k goes to byte o+k. Read lane k returns byte o+k, and lanes past the touched bytes read zero. Untouched bytes keep their value.
- R7: Trigger word i sits at offset 0x40+4*i for i below NUM_TRIG, and all 32 of its bits are writable.
- R8: An unmapped offset inside the window reads as zero, and a write to it changes no register. This covers trigger index NUM_TRIG, control index NUM_IRQ and offset 0x2000.
- R9: An access outside the window is ignored. It produces no read response and changes no register, even when its low 15 address bits alias a mapped offset.
- R10: rsp_valid is high for exactly one cycle, the cycle after each in-window read request. Writes produce no response.
- R11: The control word for source i is at offset 0x1000+4*i, and each source's word is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the first byte |
| bus_len | input | 2 | Number of bytes minus one |
| bus_wdata | input | 32 | Write data; lane 0 is the first byte |
| rsp_valid | output | 1 | Read data valid (one cycle after the request) |
| rsp_rdata | output | 32 | Read data; lane 0 is the first byte |

## Verification
The bench goes after the masking corners first. A full-ones write must come back as 0xF0C70101. A design that stored the raw word, or built the level mask from the wrong end of the byte, would return a different pattern. Sub-word accesses at offsets 2 and 3 with a four-byte length check lane alignment and clipping at the word end. A design that shifted the wrong way, or spilled into the next word, would corrupt a neighbouring field or return non-zero upper lanes. Aliased out-of-window writes, writes to the index one past each array, and offsets 1 to 3 of the configuration word must all leave state alone and read as zero. A decoder that looked only at the low address bits, or used an inclusive bound, would change a register there.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CFG  = 2'd1,
    RG_TRIG = 2'd2,
    RG_INT  = 2'd3
  } region_e;

  localparam logic [7:0]  CFG_WMASK  = 8'h1E;
  localparam logic [7:0]  CFG_RESET  = 8'h30;
  localparam logic [7:0]  ATTR_WMASK = 8'hC7;
  localparam logic [7:0]  FLAG_WMASK = 8'h01;
  localparam logic [12:0] TRIG_WORD0 = 13'h010;
  localparam logic [12:0] INT_WORD0  = 13'h400;

  // Writable bits of the level byte: top `bits` bits set.
  function automatic logic [7:0] level_mask(input int unsigned bits);
    logic [7:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b >= 8 - int'(bits)) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] ctl_word_mask(input int unsigned bits);
    return {level_mask(bits), ATTR_WMASK, FLAG_WMASK, FLAG_WMASK};
  endfunction

  // Bytes of the word that an access touches.
  function automatic logic [3:0] touched_bytes(input logic [1:0] offs,
                                               input logic [1:0] len);
    logic [3:0] be;
    logic [2:0] last;
    last = {1'b0, offs} + {1'b0, len};
    for (int b = 0; b < 4; b++) begin
      be[b] = (3'(b) >= {1'b0, offs}) && (3'(b) <= last);
    end
    return be;
  endfunction

  function automatic logic [31:0] expand_bytes(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] BASE     = 32'hC000_0000,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned NUM_TRIG = 0,
  parameter int unsigned IW       = 4,
  parameter int unsigned TW       = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output region_e           region,
  output logic [1:0]        offs,
  output logic [IW-1:0]     idx_int,
  output logic [TW-1:0]     idx_trig
);
  localparam logic [ADDR_W-1:0] BASE_A   = BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(32'h8000);
  localparam logic [12:0]       INT_END  = 13'(INT_WORD0 + 13'(NUM_IRQ));
  localparam logic [12:0]       TRIG_END = 13'(TRIG_WORD0 + 13'(NUM_TRIG));

  logic [ADDR_W-1:0] rel;
  logic [12:0]       word;
  logic [12:0]       wi_int;
  logic [12:0]       wi_trig;
  logic              hit_cfg;
  logic              hit_trig;
  logic              hit_int;

  always_comb begin
    rel      = addr - BASE_A;
    in_win   = (addr >= BASE_A) && (rel < WIN_SIZE);
    word     = rel[14:2];
    offs     = rel[1:0];
    wi_int   = word - INT_WORD0;
    wi_trig  = word - TRIG_WORD0;
    idx_int  = wi_int[IW-1:0];
    idx_trig = wi_trig[TW-1:0];
    hit_cfg  = in_win && (rel[14:0] == 15'd0);
    hit_trig = in_win && (word >= TRIG_WORD0) && (word < TRIG_END);
    hit_int  = in_win && (word >= INT_WORD0) && (word < INT_END);
    if (hit_cfg)       region = RG_CFG;
    else if (hit_trig) region = RG_TRIG;
    else if (hit_int)  region = RG_INT;
    else               region = RG_NONE;
  end
endmodule

// File: rtl/irqbank_lanes.sv
module irqbank_lanes
  import irqbank_pkg::*;
(
  input  logic [1:0]  offs,
  input  logic [1:0]  len,
  input  logic [31:0] old_word,
  input  logic [31:0] wdata,
  output logic [31:0] merged,
  output logic [31:0] rd_lanes
);
  logic [3:0]  be;
  logic [31:0] be_bits;
  logic [31:0] w_shift;
  logic [31:0] r_shift;
  logic [3:0]  lane_on;

  // A read lane is live if it is inside the length and inside the word.
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_on[k] = (2'(k) <= len) && ({1'b0, offs} + 3'(k) <= 3'd3);
  end

  always_comb begin
    be       = touched_bytes(offs, len);
    be_bits  = expand_bytes(be);
    w_shift  = wdata << {offs, 3'b000};
    r_shift  = old_word >> {offs, 3'b000};
    merged   = (old_word & ~be_bits) | (w_shift & be_bits);
    rd_lanes = r_shift & expand_bytes(lane_on);
  end
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] BASE       = 32'hC000_0000,
  parameter int unsigned NUM_IRQ    = 16,
  parameter int unsigned NUM_TRIG   = 0,
  parameter int unsigned LEVEL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_len,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned TW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [31:0] CTL_MASK = ctl_word_mask(LEVEL_BITS);

  logic          in_win;
  region_e       region;
  logic [1:0]    offs;
  logic [IW-1:0] idx_int;
  logic [TW-1:0] idx_trig;
  logic [31:0]   sel_word;
  logic [31:0]   merged;
  logic [31:0]   rd_lanes;
  logic [31:0]   trig_sel;
  logic          wr_en;
  logic          rd_en;
  logic          hit_cfg;
  logic          int_bad;

  logic [7:0]              cfg_q;
  logic [NUM_IRQ-1:0][31:0] int_q;

  irqbank_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .NUM_IRQ(NUM_IRQ),
    .NUM_TRIG(NUM_TRIG), .IW(IW), .TW(TW)
  ) u_decode (
    .addr(bus_addr), .in_win(in_win), .region(region), .offs(offs),
    .idx_int(idx_int), .idx_trig(idx_trig)
  );

  irqbank_lanes u_lanes (
    .offs(offs), .len(bus_len), .old_word(sel_word), .wdata(bus_wdata),
    .merged(merged), .rd_lanes(rd_lanes)
  );

  assign wr_en   = bus_valid && bus_write && in_win;
  assign rd_en   = bus_valid && !bus_write && in_win;
  assign hit_cfg = (region == RG_CFG);

  // Configuration byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_en && hit_cfg)
      cfg_q <= (cfg_q & ~CFG_WMASK) | (merged[7:0] & CFG_WMASK);
  end

  // Per-source control words
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_int
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_q[i] <= '0;
      else if (wr_en && region == RG_INT && idx_int == IW'(i))
        int_q[i] <= merged & CTL_MASK;
    end
  end

  // Trigger words, present only when configured
  if (NUM_TRIG > 0) begin : g_trig
    logic [NUM_TRIG-1:0][31:0] trig_q;
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q[t] <= '0;
        else if (wr_en && region == RG_TRIG && idx_trig == TW'(t))
          trig_q[t] <= merged;
      end
    end
    assign trig_sel = trig_q[idx_trig];
  end else begin : g_no_trig
    assign trig_sel = '0;
  end

  always_comb begin
    case (region)
      RG_CFG:  sel_word = {24'h0, cfg_q};
      RG_TRIG: sel_word = trig_sel;
      RG_INT:  sel_word = int_q[idx_int];
      default: sel_word = '0;
    endcase
  end

  always_comb begin
    int_bad = 1'b0;
    for (int i = 0; i < int'(NUM_IRQ); i++)
      int_bad = int_bad | (|(int_q[i] & ~CTL_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_lanes;
    end
  end
endmodule

// File: rtl/irqbank_checker.sv
module irqbank_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        in_win,
  input logic        hit_cfg,
  input logic [7:0]  cfg_q,
  input logic        int_bad,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata
);
  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && in_win) |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write && in_win) |=> !rsp_valid);

  // R2
  cfg_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cfg_q & 8'hE1) == ($past(cfg_q) & 8'hE1)));

  // R9
  outside_no_cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !in_win) |=> $stable(cfg_q));

  // R3
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && hit_cfg) |=> (rsp_rdata[31:8] == 24'h0));

  // R4
  ctl_mask_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_bad);
endmodule

bind irqbank_top irqbank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .in_win(in_win), .hit_cfg(hit_cfg), .cfg_q(cfg_q), .int_bad(int_bad),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_irqbank_top.sv
module tb_irqbank_top;
  localparam logic [31:0] BASE = 32'hC000_0000;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_len = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqbank_top #(.ADDR_W(32), .BASE(BASE), .NUM_IRQ(16), .NUM_TRIG(NT),
                .LEVEL_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] len,
                    input logic [31:0] d, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_len = len;
    bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check({req, " no rsp on write"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] len,
                    input logic exp_vld, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_len = len;
    @(negedge clk);
    bus_valid = 1'b0;
    check({req, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, exp_vld});
    if (exp_vld) check({req, " data"}, rsp_rdata, exp);
  endtask

  function automatic logic [31:0] irq_addr(input int i);
    return BASE + 32'h1000 + 32'(4 * i);
  endfunction

  // Control word mask restated from the field list: level top 4 bits.
  function automatic logic [31:0] ctl_keep(input logic [31:0] v);
    logic [7:0] lvl;
    lvl = 8'hFF;
    lvl[3:0] = 4'h0;
    return v & {lvl, 8'hC7, 8'h01, 8'h01};
  endfunction

  task automatic t_reset();
    rd(BASE, 2'd0, 1'b1, 32'h30, "R1 cfg reset");
    rd(irq_addr(0), 2'd3, 1'b1, 32'h0, "R1 irq0 reset");
    rd(irq_addr(15), 2'd3, 1'b1, 32'h0, "R1 irq15 reset");
    rd(BASE + 32'h44, 2'd3, 1'b1, 32'h0, "R1 trig1 reset");
  endtask

  task automatic t_latency();
    rd(irq_addr(1), 2'd3, 1'b1, 32'h0, "R10 read pulse");
    @(negedge clk);
    check("R10 single-cycle pulse", {31'd0, rsp_valid}, 32'd0);
    wr(irq_addr(1), 2'd3, 32'h0, "R10");
  endtask

  task automatic t_cfg();
    wr(BASE, 2'd0, 32'hFF, "R2");
    rd(BASE, 2'd0, 1'b1, 32'h3E, "R2 cfg set ones");
    wr(BASE, 2'd0, 32'h00, "R2");
    rd(BASE, 2'd0, 1'b1, 32'h20, "R2 cfg clear");
    rd(BASE, 2'd3, 1'b1, 32'h20, "R3 cfg upper lanes zero");
    wr(BASE + 32'h1, 2'd0, 32'hFF, "R3");
    rd(BASE + 32'h1, 2'd2, 1'b1, 32'h0, "R3 cfg offset1 unmapped");
    rd(BASE, 2'd0, 1'b1, 32'h20, "R3 cfg untouched by offset1 write");
  endtask

  task automatic t_mask();
    wr(irq_addr(3), 2'd3, 32'hFFFF_FFFF, "R4");
    rd(irq_addr(3), 2'd3, 1'b1, 32'hF0C7_0101, "R5 full-ones mask");
    wr(irq_addr(3), 2'd3, 32'hA5A5_A5A5, "R4");
    rd(irq_addr(3), 2'd3, 1'b1, ctl_keep(32'hA5A5_A5A5), "R4 pattern mask");
    rd(irq_addr(3) + 32'd3, 2'd0, 1'b1, 32'h0000_00A0, "R5 level byte");
  endtask

  task automatic t_subword();
    wr(irq_addr(5), 2'd3, 32'h0, "R6");
    wr(irq_addr(5) + 32'd3, 2'd3, 32'hFFFF_FF80, "R6");
    rd(irq_addr(5), 2'd3, 1'b1, 32'h8000_0000, "R6 offset3 one byte");
    rd(irq_addr(6), 2'd3, 1'b1, 32'h0, "R6 no spill to next word");
    wr(irq_addr(5) + 32'd1, 2'd1, 32'hFFFF_C701, "R6");
    rd(irq_addr(5), 2'd3, 1'b1, 32'h80C7_0100, "R6 offset1 two bytes");
    rd(irq_addr(5) + 32'd2, 2'd1, 1'b1, 32'h0000_80C7, "R6 read offset2");
    rd(irq_addr(5) + 32'd3, 2'd3, 1'b1, 32'h0000_0080, "R6 read offset3 clip");
    rd(irq_addr(5) + 32'd1, 2'd0, 1'b1, 32'h0000_0001, "R6 read one byte");
  endtask

  task automatic t_trig();
    wr(BASE + 32'h44, 2'd3, 32'hDEAD_BEEF, "R7");
    rd(BASE + 32'h44, 2'd3, 1'b1, 32'hDEAD_BEEF, "R7 trig1 full width");
    rd(BASE + 32'h40, 2'd3, 1'b1, 32'h0, "R7 trig0 untouched");
    wr(BASE + 32'h48, 2'd3, 32'h1234_5678, "R8");
    rd(BASE + 32'h48, 2'd3, 1'b1, 32'h0, "R8 trig index NT unmapped");
  endtask

  task automatic t_unmapped();
    wr(irq_addr(16), 2'd3, 32'hFFFF_FFFF, "R8");
    rd(irq_addr(16), 2'd3, 1'b1, 32'h0, "R8 irq index 16 unmapped");
    rd(irq_addr(15), 2'd3, 1'b1, 32'h0, "R8 irq15 unchanged");
    rd(BASE + 32'h2000, 2'd3, 1'b1, 32'h0, "R8 offset 0x2000");
  endtask

  task automatic t_window();
    rd(BASE + 32'h8000, 2'd3, 1'b0, 32'h0, "R9 read above window");
    rd(BASE - 32'h4, 2'd3, 1'b0, 32'h0, "R9 read below window");
    wr(BASE + 32'h8000 + 32'h100C, 2'd3, 32'hFFFF_FFFF, "R9");
    wr(BASE + 32'h8000, 2'd0, 32'h1E, "R9");
    rd(irq_addr(3), 2'd3, 1'b1, ctl_keep(32'hA5A5_A5A5), "R9 alias no write");
    rd(BASE, 2'd0, 1'b1, 32'h20, "R9 cfg unchanged");
  endtask

  task automatic t_index();
    wr(irq_addr(0), 2'd3, 32'h1000_0001, "R11");
    wr(irq_addr(15), 2'd3, 32'hE000_0100, "R11");
    rd(irq_addr(0), 2'd3, 1'b1, 32'h1000_0001, "R11 irq0");
    rd(irq_addr(15), 2'd3, 1'b1, 32'hE000_0100, "R11 irq15");
    rd(irq_addr(7), 2'd3, 1'b1, 32'h0, "R11 irq7 independent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_cfg();
    t_mask();
    t_subword();
    t_trig();
    t_unmapped();
    t_window();
    t_index();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule